// File: doc/BRIEF.md
# Multi-Link Sorted Tag Queue

This block keeps packet tags for several output links in one shared, sorted array of slots, so that the links draw on a common pool of storage instead of each holding its own queue. Every stored entry carries a link number, a priority value and a payload tag. The array is kept ordered by link first and priority second, so the entries of one link always form a single contiguous run. Within a run, a smaller priority value ranks as more urgent.

A push sends the new entry to every slot at once. Each slot then decides locally whether to keep its entry, take the new one, or take its front neighbour's entry. A pop names a link and picks either the head of that link's run (its most urgent entry) or the tail (its least urgent entry). The one matching slot is gated onto a shared result bus, and only the entries behind it move one slot forward. Results are registered and appear one cycle after the command.

Top module: `mlink_pq`

## Requirements
- R1: After reset, `out_valid_o`, `miss_o`, `err_o` and `full_o` are all low, and a pop of any link reports a miss.
- R2: Entries are ordered by the key {link, priority}, with the link in the upper bits and a smaller priority value more urgent. A head pop of a link returns that link's entry with the smallest priority value.
- R3: Entries with equal link and priority leave a head pop in the order they were pushed, because a push lands behind every stored entry whose key is less than or equal to its own.
- R4: A head pop (`pop_head_i`) of a link that holds entries gives `out_valid_o`=1 with that entry's `out_prio_o` and `out_tag_o` in the cycle after the command, and removes the entry.
- R5: A tail pop (`pop_tail_i`) returns and removes the named link's last entry: the one with the largest priority value, and the latest pushed among equals.
- R6: A pop changes neither the order nor the content of the remaining entries of the same link or of any other link.
- R7: A pop of a link with no stored entry gives `miss_o`=1 and `out_valid_o`=0 in the next cycle, and leaves the stored entries unchanged.
- R8: `full_o` is high while all DEPTH slots hold entries. A push into a full array discards the entry that sorts last overall, which may be the pushed entry itself.
- R9: When more than one of `push_i`, `pop_head_i` and `pop_tail_i` is high in a cycle, `err_o`=1 in the next cycle, `out_valid_o`=0, and the stored entries do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Insert the entry given on link_i, prio_i and tag_i |
| pop_head_i | input | 1 | Remove the most urgent entry of link_i |
| pop_tail_i | input | 1 | Remove the least urgent entry of link_i |
| link_i | input | LINK_W | Link number, for a push or a pop |
| prio_i | input | PRIO_W | Priority of the pushed entry; smaller is more urgent |
| tag_i | input | TAG_W | Payload tag of the pushed entry |
| out_valid_o | output | 1 | A pop found an entry; the result is on out_prio_o and out_tag_o |
| out_prio_o | output | PRIO_W | Priority of the popped entry |
| out_tag_o | output | TAG_W | Tag of the popped entry |
| miss_o | output | 1 | A pop named a link that holds no entry |
| full_o | output | 1 | Every slot holds an entry |
| err_o | output | 1 | Conflicting commands were given in the previous cycle |

## Verification
The bench uses the defaults: 8 slots, 4 links, 3-bit priorities and 5-bit tags. With only 8 slots, a long pseudo-random run of pushes and both kinds of pop keeps reaching full arrays, empty links, single-entry runs and runs that cover the whole array, and every pop is compared against an arithmetic model of the sorted list. Directed sequences cover equal-key ordering, overflow of a full array by both a very urgent push and a least-urgent push, and conflicting commands.

// File: rtl/mlink_pq_pkg.sv
package mlink_pq_pkg;

  typedef enum logic [1:0] {
    CMD_IDLE,
    CMD_PUSH,
    CMD_POP_HEAD,
    CMD_POP_TAIL
  } cmd_e;

  function automatic logic cmd_clash(input logic push, input logic head, input logic tail);
    return (push & head) | (push & tail) | (head & tail);
  endfunction

  function automatic cmd_e cmd_decode(input logic push, input logic head, input logic tail);
    if (cmd_clash(push, head, tail)) return CMD_IDLE;
    if (push) return CMD_PUSH;
    if (head) return CMD_POP_HEAD;
    if (tail) return CMD_POP_TAIL;
    return CMD_IDLE;
  endfunction

endpackage

// File: rtl/mlink_pq_slot.sv
// One sorted slot; entry layout {valid, link, prio, tag}, key = {link, prio}.
module mlink_pq_slot #(
  parameter int EW    = 12,
  parameter int KEY_W = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pull_i,
  input  logic [EW-1:0] new_i,
  input  logic [EW-1:0] prev_i,
  input  logic          prev_stay_i,
  input  logic [EW-1:0] next_i,
  output logic          stay_o,
  output logic [EW-1:0] entry_o
);

  logic [EW-1:0] entry_q;

  // keep entry when its key is <= the broadcast key (FIFO among equals)
  assign stay_o  = entry_q[EW-1] && (entry_q[EW-2 -: KEY_W] <= new_i[EW-2 -: KEY_W]);
  assign entry_o = entry_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_q <= '0;
    end else if (push_i) begin
      if (!stay_o) entry_q <= prev_stay_i ? new_i : prev_i;
    end else if (pull_i) begin
      entry_q <= next_i;
    end
  end

  a_r6_no_push_and_pull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pull_i));

endmodule

// File: rtl/mlink_pq_outmux.sv
// Shared result bus: one-hot select into an OR reduction.
module mlink_pq_outmux #(
  parameter int N = 8,
  parameter int W = 12
) (
  input  logic [N-1:0] sel_i,
  input  logic [W-1:0] data_i [N],
  output logic [W-1:0] data_o
);

  always_comb begin
    data_o = '0;
    for (int i = 0; i < N; i++) data_o |= data_i[i] & {W{sel_i[i]}};
  end

  a_r4_sel_onehot: assert final ($onehot0(sel_i));

endmodule

// File: rtl/mlink_pq.sv
module mlink_pq
  import mlink_pq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LINKS  = 4,
  parameter int PRIO_W = 3,
  parameter int TAG_W  = 5,
  localparam int LINK_W = (LINKS > 1) ? $clog2(LINKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_head_i,
  input  logic              pop_tail_i,
  input  logic [LINK_W-1:0] link_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              out_valid_o,
  output logic [PRIO_W-1:0] out_prio_o,
  output logic [TAG_W-1:0]  out_tag_o,
  output logic              miss_o,
  output logic              full_o,
  output logic              err_o
);

  localparam int KEY_W = LINK_W + PRIO_W;
  localparam int EW    = 1 + KEY_W + TAG_W;

  cmd_e cmd;
  logic clash;
  logic is_pop, hit;

  logic [EW-1:0]    slot   [DEPTH];
  logic [DEPTH-1:0] stay, valid, match, first, last, sel, behind;
  logic [EW-1:0]    new_entry, bus;

  assign clash     = cmd_clash(push_i, pop_head_i, pop_tail_i);
  assign cmd       = cmd_decode(push_i, pop_head_i, pop_tail_i);
  assign is_pop    = (cmd == CMD_POP_HEAD) || (cmd == CMD_POP_TAIL);
  assign new_entry = {1'b1, link_i, prio_i, tag_i};

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [EW-1:0] prev_e, next_e;
    logic          prev_s;
    if (i == 0) begin : g_front
      assign prev_e = '0;
      assign prev_s = 1'b1;
    end else begin : g_mid
      assign prev_e = slot[i-1];
      assign prev_s = stay[i-1];
    end
    if (i == DEPTH - 1) begin : g_back
      assign next_e = '0;
    end else begin : g_inner
      assign next_e = slot[i+1];
    end

    mlink_pq_slot #(.EW(EW), .KEY_W(KEY_W)) i_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .push_i      (cmd == CMD_PUSH),
      .pull_i      (is_pop && behind[i]),
      .new_i       (new_entry),
      .prev_i      (prev_e),
      .prev_stay_i (prev_s),
      .next_i      (next_e),
      .stay_o      (stay[i]),
      .entry_o     (slot[i])
    );

    assign valid[i] = slot[i][EW-1];
    assign match[i] = valid[i] && (slot[i][EW-2 -: LINK_W] == link_i);
  end

  // runs are contiguous, so head/tail of a run is a local edge test
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      first[i] = match[i] && ((i == 0) ? 1'b1 : !match[(i == 0) ? 0 : i-1]);
      last[i]  = match[i] && ((i == DEPTH-1) ? 1'b1 : !match[(i == DEPTH-1) ? i : i+1]);
    end
    sel = (cmd == CMD_POP_HEAD) ? first : (cmd == CMD_POP_TAIL) ? last : '0;
    behind[0] = sel[0];
    for (int i = 1; i < DEPTH; i++) behind[i] = behind[i-1] | sel[i];
  end

  assign hit = |sel;

  mlink_pq_outmux #(.N(DEPTH), .W(EW)) i_outmux (
    .sel_i  (sel),
    .data_i (slot),
    .data_o (bus)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_prio_o  <= '0;
      out_tag_o   <= '0;
      miss_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      out_valid_o <= is_pop && hit;
      miss_o      <= is_pop && !hit;
      err_o       <= clash;
      if (is_pop && hit) begin
        out_prio_o <= bus[TAG_W +: PRIO_W];
        out_tag_o  <= bus[TAG_W-1:0];
      end
    end
  end

  assign full_o = valid[DEPTH-1];

  // ---- assertions ----
  for (genvar i = 0; i < DEPTH - 1; i++) begin : g_chk
    a_r2_sorted: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid[i+1] |-> (valid[i] && slot[i][EW-2 -: KEY_W] <= slot[i+1][EW-2 -: KEY_W]));
  end

  a_r9_clash_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clash |=> (err_o && !out_valid_o && $stable(valid)));

  a_r7_miss_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pop && !hit) |=> (miss_o && !out_valid_o && $stable(valid)));

  a_r4_hit_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pop && hit) |=> (out_valid_o && !miss_o));

  a_r8_full_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && cmd == CMD_PUSH) |=> full_o);

endmodule

// File: tb/test_mlink_pq.sv
module test_mlink_pq;

  localparam int D = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       push_i = 0, pop_head_i = 0, pop_tail_i = 0;
  logic [1:0] link_i = '0;
  logic [2:0] prio_i = '0;
  logic [4:0] tag_i = '0;
  logic       out_valid_o, miss_o, full_o, err_o;
  logic [2:0] out_prio_o;
  logic [4:0] out_tag_o;

  mlink_pq i_mlink_pq (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  bit done = 0;

  // model of the sorted array
  int m_link [D], m_prio [D], m_tag [D];
  int m_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int key(input int l, input int p);
    return l * 8 + p;
  endfunction

  task automatic model_push(input int l, input int p, input int t);
    int pos = m_cnt;
    for (int i = m_cnt - 1; i >= 0; i--)
      if (key(m_link[i], m_prio[i]) > key(l, p)) pos = i;
    if (pos >= D) return;
    for (int i = D - 1; i > pos; i--) begin
      m_link[i] = m_link[i-1]; m_prio[i] = m_prio[i-1]; m_tag[i] = m_tag[i-1];
    end
    m_link[pos] = l; m_prio[pos] = p; m_tag[pos] = t;
    if (m_cnt < D) m_cnt++;
  endtask

  // returns index to remove, or -1
  function automatic int model_find(input int l, input bit tail);
    int idx = -1;
    for (int i = 0; i < m_cnt; i++)
      if (m_link[i] == l && (tail || idx < 0)) idx = i;
    return idx;
  endfunction

  task automatic model_remove(input int idx);
    for (int i = idx; i < m_cnt - 1; i++) begin
      m_link[i] = m_link[i+1]; m_prio[i] = m_prio[i+1]; m_tag[i] = m_tag[i+1];
    end
    m_cnt--;
  endtask

  // one command cycle; outputs sampled at the following negedge
  task automatic step(input bit ps, input bit hd, input bit tl, input int l, input int p, input int t,
                      input string req);
    int idx;
    bit clash = (ps & hd) | (ps & tl) | (hd & tl);
    @(negedge clk_i);
    push_i = ps; pop_head_i = hd; pop_tail_i = tl;
    link_i = l[1:0]; prio_i = p[2:0]; tag_i = t[4:0];
    @(negedge clk_i);
    push_i = 0; pop_head_i = 0; pop_tail_i = 0;
    if (clash) begin
      chk(err_o == 1'b1 && out_valid_o == 1'b0, "R9 clash", err_o, 1);
    end else begin
      chk(err_o == 1'b0, {req, " err"}, err_o, 0);
      if (ps) model_push(l, p, t);
      if (hd || tl) begin
        idx = model_find(l, tl);
        if (idx < 0) begin
          chk(miss_o == 1'b1 && out_valid_o == 1'b0, {req, " R7 miss"}, miss_o, 1);
        end else begin
          chk(out_valid_o == 1'b1 && miss_o == 1'b0, {req, " valid"}, out_valid_o, 1);
          chk(out_tag_o == m_tag[idx][4:0], {req, " tag"}, out_tag_o, m_tag[idx]);
          chk(out_prio_o == m_prio[idx][2:0], {req, " prio"}, out_prio_o, m_prio[idx]);
          model_remove(idx);
        end
      end
    end
    chk(full_o == (m_cnt == D), {req, " R8 full"}, full_o, m_cnt == D);
  endtask

  task automatic drain(input string req);
    for (int l = 0; l < 4; l++)
      while (model_find(l, 0) >= 0) step(0, 1, 0, l, 0, 0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    int r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(out_valid_o == 0 && miss_o == 0 && err_o == 0 && full_o == 0, "R1 reset outputs",
        {out_valid_o, miss_o, err_o, full_o}, 0);
    step(0, 1, 0, 2, 0, 0, "R1 empty pop");

    // R3 FIFO among equal keys, R2 ordering across priorities
    step(1, 0, 0, 1, 3, 1, "R3 push");
    step(1, 0, 0, 1, 3, 2, "R3 push");
    step(1, 0, 0, 1, 1, 3, "R2 push");
    step(1, 0, 0, 1, 3, 4, "R3 push");
    step(1, 0, 0, 0, 7, 5, "R6 push other link");
    step(1, 0, 0, 2, 0, 6, "R6 push other link");
    step(0, 1, 0, 1, 0, 0, "R2 head");
    step(0, 0, 1, 1, 0, 0, "R5 tail");
    step(0, 1, 0, 1, 0, 0, "R3 head");
    step(0, 1, 0, 3, 0, 0, "R7 empty link");
    drain("R6 drain");

    // R9 clash leaves state untouched
    step(1, 0, 0, 3, 2, 9, "R9 setup");
    step(1, 1, 0, 3, 0, 10, "R9 push+head");
    step(0, 1, 1, 3, 0, 0, "R9 head+tail");
    step(1, 0, 1, 3, 0, 11, "R9 push+tail");
    step(0, 1, 0, 3, 0, 0, "R9 after clash");

    // R8 fill, overflow with urgent and least-urgent entries
    for (int i = 0; i < D; i++) step(1, 0, 0, i % 4, 7 - i, 12 + i, "R8 fill");
    step(1, 0, 0, 0, 0, 30, "R8 overflow urgent");
    step(1, 0, 0, 3, 7, 31, "R8 overflow last");
    drain("R8 drain");

    // pseudo-random sweep: R2 R4 R5 R6 R7 R8
    for (int n = 0; n < 3000; n++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      r = lf;
      case (r % 8)
        0, 1, 2, 7: step(1, 0, 0, (r >> 3) % 4, (r >> 5) % 8, n % 32, "R4 sweep push");
        3, 4:       step(0, 1, 0, (r >> 3) % 4, 0, 0, "R4 sweep head");
        5:          step(0, 0, 1, (r >> 3) % 4, 0, 0, "R5 sweep tail");
        default:    step(((r >> 8) % 2) == 1, 1, (r >> 9) % 2 == 1, (r >> 3) % 4, 0, 0,
                         "R9 sweep");
      endcase
    end
    drain("R6 final drain");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule